// File: doc/BRIEF.md
# Serial EEPROM Byte Read Sequencer

This block fetches a run of bytes, such as a stored station address, from a small serial EEPROM with an SPI port and 8-bit addressing. It drives the memory's select, clock and data-out pins and samples the memory's data-out line. A host asks for a transfer with a one-cycle `start`, giving a first address, a byte count and a mode. Read mode returns memory contents. Status mode returns the memory's status byte once per requested byte.

Each byte is fetched in a transaction of its own. Select falls, the controller sends an 8-bit instruction (followed by an 8-bit address in read mode), eight data bits are clocked in, and then select rises again. After each transaction comes a quiet pause. Each pin level is held for a whole dwell time, which a divider sets from `HALF_DIV` system clock cycles. The first transfer after reset is preceded by a wake-up preamble of clock pulses sent with select high.

Fetched bytes leave on a valid/ready stream. `out_valid` rises once a byte has been captured and select has been released. `out_data` then holds still until the handshake cycle, when `out_valid && out_ready` are both high. While the byte waits for `out_ready`, the bus stays idle, so back-pressure only stretches the gap between transactions.

Top module: `eeprom_rd_seq`

## Requirements
- R1: While reset is high, and at all times when not busy, the select pin is high (select is active low) and the clock pin is low. A synchronous reset during a transfer abandons the transfer and re-arms the wake-up preamble.
- R2: Before the first transaction after reset, exactly two clock pulses (WAKE_PULSES) are sent while select stays high. No later transfer sends a preamble.
- R3: The data-out pin changes only while the clock is low, and it is stable through every high clock phase. Select falls only while the clock is low.
- R4: A read-mode transaction shifts out opcode 0x03 and then the 8-bit address, each MSB first, on 16 rising edges. It then gives 8 more rising edges. The data bit that the memory presents after each of the falling edges 16 through 23 (counting from 1) is captured MSB first. The whole transaction uses exactly 24 rising edges.
- R5: A status-mode transaction shifts out opcode 0x05 MSB first, with no address phase. It captures 8 bits MSB first after the falling edges 8 through 15, for exactly 16 rising edges in all.
- R6: Every level of the select, clock and data-out pins is held for at least HALF_DIV system clock cycles before the next change.
- R7: A transfer of N bytes produces N transactions. Select returns high between them. The address starts at `start_addr` and rises by one per byte, wrapping from 255 to 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays stable, and no bus activity occurs.
- R9: A start with a byte count of zero raises `done` on the next cycle, does not set `busy`, moves no pin, and leaves the preamble armed.
- R10: A start pulse while busy has no effect on the transfer in progress.
- R11: `done` is a one-cycle pulse in the cycle after the last byte is accepted. `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transfer |
| start_addr | input | ADDR_W | First byte address (read mode) |
| nbytes | input | CNT_W | Number of bytes to fetch |
| status_mode | input | 1 | 1 = read status byte, 0 = read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| out_data | output | 8 | Fetched byte |
| out_valid | output | 1 | Fetched byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| spi_cs_n | output | 1 | Memory select, active low |
| spi_sck | output | 1 | Serial clock to memory |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory |

## Verification
The bench replaces the memory with a 256-entry behavioural model, and it decodes opcode and address from rising edges. It sweeps every address once and also reads across the 255-to-0 wrap. The model's contents form a bijection, so a design that skipped an increment, sent the address LSB first, or sampled one falling edge early or late returns wrong bytes. The bench also checks the exact rising-edge count per transaction, which catches a design that added or dropped a clock. Further cases check a preamble repeated on each transfer or never re-armed after reset, a zero count that starts the bus, a stalled consumer whose byte changes or whose bus keeps running, a second start that hijacks the transfer in progress, and any pin level held for less than the dwell time.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  localparam int          OP_W      = 8;
  localparam int          DATA_W    = 8;
  localparam logic [7:0]  OP_RDDATA = 8'h03;
  localparam logic [7:0]  OP_RDSTAT = 8'h05;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE_HI,
    ST_WAKE_LO,
    ST_CS_SETUP,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_CS_END,
    ST_GAP,
    ST_HOLD
  } seq_state_e;

endpackage

// File: rtl/eeprom_dwell_timer.sv
module eeprom_dwell_timer #(
  parameter int HALF_DIV = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HALF_DIV > 1) begin : g_gap
      // R6
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/eeprom_frame_shifter.sv
module eeprom_frame_shifter
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_status,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              shift,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int TX_W = OP_W + ADDR_W;

  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_status ? {OP_RDSTAT, {ADDR_W{1'b0}}} : {OP_RDDATA, load_addr};
    end else if (shift) begin
      tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rx_q <= '0;
    else if (sample) rx_q <= {rx_q[DATA_W-2:0], miso};
  end

  assign mosi    = tx_q[TX_W-1];
  assign rx_byte = rx_q;

  // R3
  load_shift_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));

  // R8
  rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sample |=> $stable(rx_byte));

endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
  import eeprom_rd_pkg::*;
#(
  parameter int HALF_DIV    = 250,
  parameter int ADDR_W      = 8,
  parameter int CNT_W       = 8,
  parameter int WAKE_PULSES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  nbytes,
  input  logic              status_mode,
  output logic              busy,
  output logic              done,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int TX_W      = OP_W + ADDR_W;
  localparam int FRAME_MAX = TX_W + DATA_W;
  localparam int KW        = $clog2(FRAME_MAX + 1);
  localparam int WW        = (WAKE_PULSES > 1) ? $clog2(WAKE_PULSES) : 1;
  localparam int RW        = (HALF_DIV > 1) ? $clog2(HALF_DIV + 1) : 1;

  seq_state_e        state_q;
  logic [KW-1:0]     k_q;
  logic [WW-1:0]     wcnt_q;
  logic              wake_pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic              status_q;
  logic              valid_q;
  logic              done_q;

  logic              run, tick;
  logic              ld, ld_status, shift, sample;
  logic [ADDR_W-1:0] ld_addr;
  logic [KW-1:0]     n_out, k_last;
  logic              samp_win, wake_last;

  // ---------------- dwell timing ----------------
  assign run = (state_q != ST_IDLE) && (state_q != ST_HOLD);

  eeprom_dwell_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  // ---------------- frame geometry ----------------
  assign n_out     = status_q ? KW'(OP_W) : KW'(TX_W);
  assign k_last    = n_out + KW'(DATA_W - 1);
  assign samp_win  = (k_q >= n_out - KW'(1)) && (k_q <= n_out + KW'(DATA_W - 2));
  assign wake_last = (wcnt_q == WW'(WAKE_PULSES - 1));

  // ---------------- shifter control ----------------
  always_comb begin
    ld        = 1'b0;
    ld_status = status_q;
    ld_addr   = addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start && (nbytes != '0) && !wake_pend_q) begin
          ld        = 1'b1;
          ld_status = status_mode;
          ld_addr   = start_addr;
        end
      end
      ST_WAKE_LO: ld = tick && wake_last;
      ST_HOLD: begin
        if (out_ready && (rem_q != CNT_W'(1))) begin
          ld      = 1'b1;
          ld_addr = addr_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign shift  = (state_q == ST_CLK_HI) && tick;
  assign sample = (state_q == ST_CLK_LO) && tick && samp_win;

  eeprom_frame_shifter #(.ADDR_W(ADDR_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .load        (ld),
    .load_status (ld_status),
    .load_addr   (ld_addr),
    .shift       (shift),
    .sample      (sample),
    .miso        (spi_miso),
    .mosi        (spi_mosi),
    .rx_byte     (out_data)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      k_q         <= '0;
      wcnt_q      <= '0;
      wake_pend_q <= 1'b1;
      addr_q      <= '0;
      rem_q       <= '0;
      status_q    <= 1'b0;
      valid_q     <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (nbytes == '0) begin
              done_q <= 1'b1;
            end else begin
              addr_q   <= start_addr;
              rem_q    <= nbytes;
              status_q <= status_mode;
              if (wake_pend_q) begin
                wcnt_q  <= '0;
                state_q <= ST_WAKE_HI;
              end else begin
                state_q <= ST_CS_SETUP;
              end
            end
          end
        end
        ST_WAKE_HI: if (tick) state_q <= ST_WAKE_LO;
        ST_WAKE_LO: begin
          if (tick) begin
            if (wake_last) begin
              wake_pend_q <= 1'b0;
              state_q     <= ST_CS_SETUP;
            end else begin
              wcnt_q  <= wcnt_q + 1'b1;
              state_q <= ST_WAKE_HI;
            end
          end
        end
        ST_CS_SETUP: begin
          if (tick) begin
            k_q     <= '0;
            state_q <= ST_CLK_HI;
          end
        end
        ST_CLK_HI: if (tick) state_q <= ST_CLK_LO;
        ST_CLK_LO: begin
          if (tick) begin
            if (k_q == k_last) begin
              state_q <= ST_CS_END;
            end else begin
              k_q     <= k_q + 1'b1;
              state_q <= ST_CLK_HI;
            end
          end
        end
        ST_CS_END: if (tick) state_q <= ST_GAP;
        ST_GAP: begin
          if (tick) begin
            valid_q <= 1'b1;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) begin
            valid_q <= 1'b0;
            if (rem_q == CNT_W'(1)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              addr_q  <= addr_q + 1'b1;
              rem_q   <= rem_q - 1'b1;
              state_q <= ST_CS_SETUP;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    spi_cs_n = !((state_q == ST_CS_SETUP) || (state_q == ST_CLK_HI) ||
                 (state_q == ST_CLK_LO));
    spi_sck  = (state_q == ST_WAKE_HI) || (state_q == ST_CLK_HI);
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign out_valid = valid_q;

  // ---------------- assertions ----------------
  logic [2:0]    pins_q;
  logic [RW-1:0] run_len_q;
  logic          armed_q;
  logic [2:0]    pins_now;

  assign pins_now = {spi_cs_n, spi_sck, spi_mosi};

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q    <= 3'b100;
      run_len_q <= '0;
      armed_q   <= 1'b0;
    end else begin
      pins_q <= pins_now;
      if (pins_now != pins_q) begin
        run_len_q <= '0;
        armed_q   <= 1'b1;
      end else if (run_len_q != RW'(HALF_DIV)) begin
        run_len_q <= run_len_q + 1'b1;
      end
    end
  end

  // R6
  dwell_min_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && (pins_now != pins_q)) |-> (run_len_q >= RW'(HALF_DIV - 1)));

  // R3
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  bus_quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (spi_cs_n && !spi_sck));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !out_valid && spi_cs_n));

endmodule

// File: tb/eeprom_rd_seq_bench.sv
module eeprom_rd_seq_bench;
  localparam int HD = 3;
  localparam logic [7:0] STAT_VAL = 8'hA6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] start_addr = '0;
  logic [7:0] nbytes = '0;
  logic       status_mode = 1'b0;
  logic       out_ready = 1'b1;
  logic       spi_miso = 1'b0;
  logic       busy, done, out_valid, spi_cs_n, spi_sck, spi_mosi;
  logic [7:0] out_data;

  eeprom_rd_seq #(.HALF_DIV(HD)) u_eeprom_rd_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .nbytes(nbytes), .status_mode(status_mode), .busy(busy), .done(done),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int a);
    int v;
    v = (a % 256) * 37 + 11;
    return v[7:0];
  endfunction

  // ---------------- memory model ----------------
  int         rcnt = 0;
  logic [7:0] m_cmd = '0, m_addr = '0;
  logic [7:0] exp_cmd = 8'h03, exp_addr = '0;
  int         wake_rises = 0, all_rises = 0, txn_done = 0;

  always @(negedge spi_cs_n) begin
    rcnt = 0; m_cmd = '0; m_addr = '0;
    chk(spi_sck == 1'b0, "R3", "clock level at select fall", spi_sck, 0);
  end

  always @(posedge spi_sck) begin
    all_rises++;
    if (spi_cs_n === 1'b1) wake_rises++;
    else begin
      if (rcnt < 8)       m_cmd  = {m_cmd[6:0], spi_mosi};
      else if (rcnt < 16) m_addr = {m_addr[6:0], spi_mosi};
      rcnt++;
    end
  end

  always @(negedge spi_sck) begin
    if (spi_cs_n === 1'b0) begin
      logic [7:0] b;
      b = mem_byte(int'(m_addr));
      if (m_cmd == 8'h03 && rcnt >= 16 && rcnt < 24)     spi_miso = b[23 - rcnt];
      else if (m_cmd == 8'h05 && rcnt >= 8 && rcnt < 16) spi_miso = STAT_VAL[15 - rcnt];
      else                                               spi_miso = 1'b0;
    end
  end

  always @(spi_mosi) begin
    if (spi_cs_n === 1'b0)
      chk(spi_sck == 1'b0, "R3", "data changed with clock high", spi_sck, 0);
  end

  always @(posedge spi_cs_n) begin
    if (!rst && rcnt > 0) begin
      int full;
      full = (exp_cmd == 8'h03) ? 24 : 16;
      if (exp_cmd == 8'h03) begin
        chk(rcnt == full, "R4", "rising edges per read", rcnt, full);
        chk(m_cmd == 8'h03, "R4", "read opcode", m_cmd, 3);
        chk(m_addr == exp_addr, "R7", "address sent", m_addr, exp_addr);
      end else begin
        chk(rcnt == full, "R5", "rising edges per status", rcnt, full);
        chk(m_cmd == 8'h05, "R5", "status opcode", m_cmd, 5);
      end
      exp_addr = exp_addr + 8'd1;
      txn_done++;
    end
  end

  // ---------------- byte collector ----------------
  logic [7:0] got[$];
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) got.push_back(out_data);
  end

  // ---------------- dwell monitor (R6) ----------------
  logic [2:0] prev_pins = 3'b100;
  int run_len = 0, min_run = 1000;
  bit seen = 1'b0;
  always @(negedge clk) begin
    logic [2:0] p;
    p = {spi_cs_n, spi_sck, spi_mosi};
    if (p !== prev_pins) begin
      if (seen && !rst && run_len < min_run) min_run = run_len;
      run_len = 1;
      seen = !rst;
    end else begin
      run_len++;
      if (rst) seen = 1'b0;
    end
    prev_pins = p;
  end

  // ---------------- tasks ----------------
  task automatic kick(input int a, input int n, input bit st);
    exp_cmd = st ? 8'h05 : 8'h03;
    exp_addr = 8'(a);
    got.delete();
    wake_rises = 0;
    @(negedge clk);
    start = 1'b1; start_addr = 8'(a); nbytes = 8'(n); status_mode = st;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 60000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R11", "done reached", done, 1);
  endtask

  task automatic check_bytes(input int a, input int n, input bit st, input string req);
    chk(got.size() == n, req, "byte count", got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++) begin
      logic [7:0] e;
      e = st ? STAT_VAL : mem_byte(a + i);
      chk(got[i] == e, req, $sformatf("byte %0d", i), got[i], e);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int t0, d;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "select in reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", "clock in reset", spi_sck, 0);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);

    // R9: zero-length request
    all_rises = 0;
    kick(0, 0, 1'b0);
    chk(done == 1'b1, "R9", "done after zero count", done, 1);
    chk(busy == 1'b0, "R9", "busy after zero count", busy, 0);
    repeat (10) @(negedge clk);
    chk(all_rises == 0, "R9", "clock edges on zero count", all_rises, 0);
    chk(spi_cs_n == 1'b1, "R9", "select on zero count", spi_cs_n, 1);

    // R4/R7 sweep of addresses 0..254; R2 preamble on first
    t0 = txn_done;
    kick(0, 255, 1'b0);
    wait_done();
    chk(wake_rises == 2, "R2", "preamble pulses first transfer", wake_rises, 2);
    chk(busy == 1'b0, "R11", "busy with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done one cycle", done, 0);
    check_bytes(0, 255, 1'b0, "R4");
    chk(txn_done - t0 == 255, "R7", "transactions", txn_done - t0, 255);

    // R7 wrap across 255
    kick(250, 10, 1'b0);
    wait_done();
    chk(wake_rises == 0, "R2", "no preamble later", wake_rises, 0);
    check_bytes(250, 10, 1'b0, "R7");

    // R5 status mode
    kick(0, 3, 1'b1);
    wait_done();
    check_bytes(0, 3, 1'b1, "R5");

    // R8 back-pressure
    out_ready = 1'b0;
    kick(7, 2, 1'b0);
    t0 = 0;
    while (!out_valid && t0 < 2000) begin @(negedge clk); t0++; end
    d = out_data;
    chk(out_valid == 1'b1, "R8", "valid appears", out_valid, 1);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R8", "valid held", out_valid, 1);
      chk(out_data == d, "R8", "data held", out_data, d);
      chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R8", "bus idle while held", spi_sck, 0);
    end
    out_ready = 1'b1;
    wait_done();
    check_bytes(7, 2, 1'b0, "R8");

    // R10 start while busy
    t0 = txn_done;
    kick(20, 3, 1'b0);
    repeat (40) @(negedge clk);
    start = 1'b1; start_addr = 8'd200; nbytes = 8'd9; status_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check_bytes(20, 3, 1'b0, "R10");
    chk(txn_done - t0 == 3, "R10", "transactions", txn_done - t0, 3);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R10", "no second transfer", busy, 0);

    // R1 reset mid-transfer re-arms preamble
    kick(60, 4, 1'b0);
    repeat (60) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "select after mid reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", "clock after mid reset", spi_sck, 0);
    chk(busy == 1'b0, "R1", "busy after mid reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    kick(61, 1, 1'b0);
    wait_done();
    chk(wake_rises == 2, "R1", "preamble re-armed", wake_rises, 2);
    check_bytes(61, 1, 1'b0, "R1");

    // R6 dwell
    chk(min_run >= HD, "R6", "shortest pin level", min_run, HD);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule